// File: doc/BRIEF.md
# ATM Transmit Cell Processor

This block produces the outgoing ATM cell stream that feeds a transmit E3 framer. At every cell boundary it picks one of three cell sources. A cell that software has requested for operations and maintenance comes first. A user cell waiting in the transmit FIFO comes next. When neither is available it makes an idle cell, which decouples the line cell rate from the user cell rate.

Every cell passes through the same two optional stages, whatever its source. The first stage computes the header error check over the first four header octets and writes it into the fifth octet. The second stage runs the 48 payload octets through a self-synchronizing scrambler. The header is never scrambled.

The output is one octet wide. It advances by one octet on every cycle in which the framer raises its ready input, and a start-of-cell flag marks the first octet of each cell. The FIFO is read through a show-ahead port: `fifo_data` is valid whenever `fifo_empty` is low, and `fifo_rd` pops it. The FIFO is expected to hold complete cells only. The software request is a one-cycle pulse that sets a pending bit, and that bit can be read back.

Top module: `atm_tx_cellproc`

## Requirements
- R1: Each cell is 53 accepted octets long. `out_soc` is high exactly while the next octet to be accepted is octet 1 of a cell.
- R2: The cell kind is chosen when octet 1 is accepted. A pending OAM request comes first, a non-empty FIFO (user cell) comes second, and an idle cell is chosen otherwise. A user cell passes the FIFO octets through in the order they are read.
- R3: An idle cell has header octets 1 to 4 equal to 0x00, 0x00, 0x00, 0x01, a source octet 5 of 0x00, and every payload octet equal to 0x6A before scrambling.
- R4: When `cfg_hec_en` is 1, octet 5 equals the CRC-8 of octets 1 to 4 XOR 0x55. The CRC uses generator x^8+x^2+x+1, a zero start value and MSB-first processing. When `cfg_hec_en` is 0, octet 5 is the source octet.
- R5: When `cfg_scr_en` is 1, each payload octet (octets 6 to 53) is scrambled MSB first. Each output bit is the input bit XOR state bit 42, and that output bit is then shifted into a 43-bit state. The state starts at zero after reset, carries over from cell to cell, and does not change while scrambling is off. Header octets are never scrambled.
- R6: An OAM cell takes octets 1 to 4 from `oam_hdr`, with octet 1 taken from bits 31:24. Its source octet 5 is 0x00, and every payload octet is `oam_fill`.
- R7: `oam_pending` is set by an `oam_req` pulse and is cleared when octet 1 of an OAM cell is accepted. If a new request arrives on that same cycle, the bit stays set.
- R8: While `out_ready` is low, no octet is accepted, `fifo_rd` stays low, and the data of any octet other than octet 1 stays the same.
- R9: `fifo_rd` is high exactly on accepted octets of user cells, which gives 53 pops per user cell.
- R10: After reset, the next octet is octet 1, no OAM request is pending and the scrambler state is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hec_en | input | 1 | Enable header check insertion |
| cfg_scr_en | input | 1 | Enable payload scrambling |
| fifo_empty | input | 1 | Transmit FIFO holds no cell |
| fifo_data | input | 8 | Show-ahead FIFO head octet |
| fifo_rd | output | 1 | Pop one FIFO octet |
| oam_req | input | 1 | Pulse requesting one OAM cell |
| oam_hdr | input | 32 | OAM header octets 1 to 4 |
| oam_fill | input | 8 | OAM payload octet value |
| oam_pending | output | 1 | OAM request not yet started |
| out_ready | input | 1 | Framer accepts an octet this cycle |
| out_data | output | 8 | Outgoing cell octet |
| out_soc | output | 1 | Octet 1 of a cell is presented |

## Verification
On every cycle the assertions check the following:
- the octet counter wraps to octet 1 after octet 53;
- a pending request always wins the boundary choice;
- the pending bit falls only on an accepted first octet;
- the position, the CRC and the scrambler state do not move during a stall or outside their octet range;
- header octets leave the block unscrambled.

Only the bench's scenarios can show that the octet values are correct. These are the idle pattern, the user cell pass-through, the OAM contents, the HEC value with insertion on and off, and the scrambler output across cell boundaries and random stalls. The bench computes all of these with its own CRC and scrambler arithmetic.

// File: rtl/atm_txcp_pkg.sv
// Shared types and the CRC step for the ATM transmit cell processor.
package atm_txcp_pkg;

    typedef enum logic [1:0] {
        CK_IDLE = 2'd0,
        CK_USER = 2'd1,
        CK_OAM  = 2'd2
    } cell_kind_e;

    // One octet of CRC-8 (x^8+x^2+x+1), MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int i = 0; i < 8; i++) begin
            r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/atm_txcp_seq.sv
// Cell sequencer: tracks the octet position, chooses the cell kind at
// each boundary and holds the OAM request bit.
// Assumes the FIFO holds whole cells, so it cannot empty inside a user cell.
module atm_txcp_seq
    import atm_txcp_pkg::*;
#(
    parameter int CELL_LEN = 53
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        adv,
    input  logic                        fifo_empty,
    input  logic                        oam_req,
    output logic [$clog2(CELL_LEN)-1:0] pos,
    output cell_kind_e                  kind,
    output logic                        first,
    output logic                        oam_pend,
    output logic                        fifo_rd
);
    localparam int PW = $clog2(CELL_LEN);
    localparam logic [PW-1:0] LAST_POS = PW'(CELL_LEN - 1);

    logic [PW-1:0] pos_q;
    cell_kind_e    kind_q, kind_sel;
    logic          pend_q, last;

    // Boundary choice: OAM first, then user, then idle.
    always_comb begin
        if (pend_q)           kind_sel = CK_OAM;
        else if (!fifo_empty) kind_sel = CK_USER;
        else                  kind_sel = CK_IDLE;
    end

    assign first    = (pos_q == '0);
    assign last     = (pos_q == LAST_POS);
    assign kind     = first ? kind_sel : kind_q;
    assign pos      = pos_q;
    assign oam_pend = pend_q;
    assign fifo_rd  = adv && (kind == CK_USER);

    // Octet position counter, advancing on each accepted octet.
    always_ff @(posedge clk) begin
        if (!rst_n)    pos_q <= '0;
        else if (adv)  pos_q <= last ? '0 : pos_q + 1'b1;
    end

    // Latch the chosen kind when octet 1 is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)             kind_q <= CK_IDLE;
        else if (adv && first)  kind_q <= kind_sel;
    end

    // OAM pending bit: a new request wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  pend_q <= 1'b0;
        else if (oam_req)                            pend_q <= 1'b1;
        else if (adv && first && kind_sel == CK_OAM) pend_q <= 1'b0;
    end

    // R1
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && last |=> first);
    // R2
    oam_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first && pend_q |-> kind == CK_OAM);
    // R7
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_q) |-> $past(adv && first));
    // R8
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pos_q));
endmodule

// File: rtl/atm_txcp_hec.sv
// Header check generator: accumulates the CRC over the header octets as
// they are accepted. The result is valid while octet 5 is presented.
module atm_txcp_hec
    import atm_txcp_pkg::*;
#(
    parameter int PW = 6,
    parameter int HB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [PW-1:0] pos,
    input  logic [7:0]    din,
    output logic [7:0]    crc
);
    logic [7:0] crc_q;
    logic       in_cov;

    assign in_cov = (pos < PW'(HB));
    assign crc    = crc_q;

    // Restart the CRC at octet 1 and fold in each covered octet.
    always_ff @(posedge clk) begin
        if (!rst_n)               crc_q <= '0;
        else if (adv && in_cov)   crc_q <= crc8_step((pos == '0) ? 8'h00 : crc_q, din);
    end

    // R4
    hec_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_cov |=> $stable(crc_q));
endmodule

// File: rtl/atm_txcp_scr.sv
// Self-synchronizing payload scrambler (x^SCR_LEN + 1), bit-serial MSB
// first and unrolled over one octet. The state moves only when stepped.
module atm_txcp_scr #(
    parameter int SCR_LEN = 43,
    parameter int W       = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [SCR_LEN-1:0] st_q, st_nxt;

    // Unrolled octet scramble: each output bit is fed back into the state.
    always_comb begin
        logic [SCR_LEN-1:0] s;
        logic               b;
        s = st_q;
        dout = '0;
        for (int i = W - 1; i >= 0; i--) begin
            b       = din[i] ^ s[SCR_LEN-1];
            dout[i] = b;
            s       = {s[SCR_LEN-2:0], b};
        end
        st_nxt = s;
    end

    // State register, cleared by reset and advanced once per payload octet.
    always_ff @(posedge clk) begin
        if (!rst_n)     st_q <= '0;
        else if (step)  st_q <= st_nxt;
    end

    // R5
    scr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(st_q));
endmodule

// File: rtl/atm_tx_cellproc.sv
// ATM transmit cell processor top. It picks the cell source, forms the
// source octet, inserts the header check and scrambles the payload.
// Assumes a show-ahead FIFO that always holds whole cells.
module atm_tx_cellproc
    import atm_txcp_pkg::*;
#(
    parameter int         CELL_LEN  = 53,
    parameter int         HDR_LEN   = 5,
    parameter int         SCR_LEN   = 43,
    parameter logic [7:0] IDLE_FILL = 8'h6A,
    parameter logic [7:0] HEC_COSET = 8'h55
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_hec_en,
    input  logic        cfg_scr_en,
    input  logic        fifo_empty,
    input  logic [7:0]  fifo_data,
    output logic        fifo_rd,
    input  logic        oam_req,
    input  logic [31:0] oam_hdr,
    input  logic [7:0]  oam_fill,
    output logic        oam_pending,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_soc
);
    localparam int PW = $clog2(CELL_LEN);
    localparam int HB = HDR_LEN - 1;

    logic [PW-1:0] pos;
    cell_kind_e    kind;
    logic          first, in_hdr, at_hec, scr_step;
    logic [7:0]    src, oam_src, idle_src, hec_raw, scr_out;

    atm_txcp_seq #(.CELL_LEN(CELL_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .adv(out_ready), .fifo_empty(fifo_empty),
        .oam_req(oam_req), .pos(pos), .kind(kind), .first(first),
        .oam_pend(oam_pending), .fifo_rd(fifo_rd)
    );

    atm_txcp_hec #(.PW(PW), .HB(HB)) u_hec (
        .clk(clk), .rst_n(rst_n), .adv(out_ready), .pos(pos),
        .din(src), .crc(hec_raw)
    );

    atm_txcp_scr #(.SCR_LEN(SCR_LEN), .W(8)) u_scr (
        .clk(clk), .rst_n(rst_n), .step(scr_step), .din(src), .dout(scr_out)
    );

    assign in_hdr   = (pos < PW'(HDR_LEN));
    assign at_hec   = (pos == PW'(HB));
    assign scr_step = out_ready && cfg_scr_en && !in_hdr;
    assign out_soc  = first;

    // OAM source octet: header bytes (octet 1 in bits 31:24), zero check slot, fill.
    always_comb begin
        oam_src = oam_fill;
        if (in_hdr) oam_src = 8'h00;
        for (int i = 0; i < HB; i++) begin
            if (pos == PW'(i)) oam_src = oam_hdr[8*(HB-1-i) +: 8];
        end
    end

    // Idle source octet: header 00 00 00 01, zero check slot, fixed fill.
    always_comb begin
        if (pos == PW'(HB - 1)) idle_src = 8'h01;
        else if (in_hdr)        idle_src = 8'h00;
        else                    idle_src = IDLE_FILL;
    end

    // Select the source octet for the current cell kind.
    always_comb begin
        case (kind)
            CK_USER: src = fifo_data;
            CK_OAM:  src = oam_src;
            default: src = idle_src;
        endcase
    end

    // Output stage: header check insertion or optional payload scrambling.
    always_comb begin
        if (at_hec && cfg_hec_en)      out_data = hec_raw ^ HEC_COSET;
        else if (!in_hdr && cfg_scr_en) out_data = scr_out;
        else                            out_data = src;
    end

    // R5
    hdr_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_hdr && !at_hec |-> out_data == src);
    // R9
    rd_only_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> out_ready && kind == CK_USER);
endmodule

// File: tb/tb_atm_tx_cellproc.sv
module tb_atm_tx_cellproc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_hec_en = 1'b1, cfg_scr_en = 1'b0;
    logic        fifo_empty, fifo_rd;
    logic [7:0]  fifo_data;
    logic        oam_req = 1'b0;
    logic [31:0] oam_hdr = 32'h0000_0018;
    logic [7:0]  oam_fill = 8'h6B;
    logic        oam_pending;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        out_soc;

    always #4 clk = ~clk;   // 125 MHz

    logic [7:0] fmem [0:1023];
    logic [9:0] wp = '0, rp = '0;
    assign fifo_empty = (wp == rp);
    assign fifo_data  = fmem[rp];

    atm_tx_cellproc dut (
        .clk(clk), .rst_n(rst_n), .cfg_hec_en(cfg_hec_en), .cfg_scr_en(cfg_scr_en),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
        .oam_req(oam_req), .oam_hdr(oam_hdr), .oam_fill(oam_fill),
        .oam_pending(oam_pending), .out_ready(out_ready),
        .out_data(out_data), .out_soc(out_soc)
    );

    int nchk = 0, nerr = 0, cells_done = 0;
    bit mon_en = 0, stall_mode = 0, done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h (cell %0d)", tag, act, exp, cells_done);
        end
    endtask

    // FIFO pop follows the DUT's read strobe.
    always @(posedge clk) if (fifo_rd) rp <= rp + 1'b1;

    // Ready pattern: constant high or pseudo-random stalls.
    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // Independent reference model.
    int         bpos = 0, bkind = 0;
    bit         bpend = 0, have_prev = 0;
    logic [7:0] bcrc = 0, prev_data = 0;
    logic [42:0] bscr = '0;

    function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int k = 7; k >= 0; k--) begin
            logic fb = r[7] ^ d[k];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    always @(negedge clk) if (mon_en && !done) begin
        logic [7:0] srcb, expb;
        string tag;
        chk(out_soc == (bpos == 0), "R1 soc", out_soc, bpos == 0);
        chk(oam_pending == bpend, "R7 pending", oam_pending, bpend);
        if (!out_ready) begin
            chk(fifo_rd == 0, "R8 rd in stall", fifo_rd, 0);
            if (bpos != 0 && have_prev) chk(out_data == prev_data, "R8 hold", out_data, prev_data);
            prev_data = out_data;
            have_prev = 1;
        end else begin
            have_prev = 0;
            if (bpos == 0) bkind = bpend ? 2 : (wp != rp ? 1 : 0);
            if (bkind == 1) begin
                srcb = fmem[rp]; tag = "R2 user";
            end else if (bkind == 2) begin
                srcb = (bpos < 4) ? oam_hdr[31 - 8*bpos -: 8] : (bpos == 4 ? 8'h00 : oam_fill);
                tag = "R6 oam";
            end else begin
                srcb = (bpos == 3) ? 8'h01 : (bpos < 5 ? 8'h00 : 8'h6A);
                tag = "R3 idle";
            end
            expb = srcb;
            if (bpos < 4) bcrc = crc_ref(bpos == 0 ? 8'h00 : bcrc, srcb);
            if (bpos == 4 && cfg_hec_en) begin
                expb = bcrc ^ 8'h55; tag = "R4 hec";
            end else if (bpos == 4) begin
                tag = "R4 hec off";
            end
            if (bpos >= 5 && cfg_scr_en) begin
                for (int k = 7; k >= 0; k--) begin
                    expb[k] = srcb[k] ^ bscr[42];
                    bscr = {bscr[41:0], expb[k]};
                end
                tag = "R5 scr";
            end
            chk(out_data == expb, tag, out_data, expb);
            chk(fifo_rd == (bkind == 1), "R9 rd", fifo_rd, bkind == 1);
            if (bpos == 0 && bkind == 2) bpend = 0;
            bpos = (bpos == 52) ? 0 : bpos + 1;
            if (bpos == 0) cells_done++;
        end
        if (oam_req) bpend = 1;
    end

    task automatic step_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push_cell(input int n);
        for (int i = 0; i < 53; i++) fmem[wp + 10'(i)] = 8'(n * 29 + i * 13 + 5);
        wp = wp + 10'd53;
    endtask

    task automatic wait_cells(input int k);
        int tgt = cells_done + k;
        while (cells_done < tgt) step_cyc(1);
    endtask

    task automatic req_oam(input logic [31:0] h, input logic [7:0] f);
        oam_hdr = h; oam_fill = f; oam_req = 1'b1;
        step_cyc(1);
        oam_req = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: after reset the next octet is octet 1 of an idle cell, nothing pending
        chk(out_soc == 1, "R10 soc", out_soc, 1);
        chk(oam_pending == 0, "R10 pending", oam_pending, 0);
        chk(out_data == 8'h00, "R10 data", out_data, 0);
        mon_en = 1;
        wait_cells(2);                           // idle, HEC on
        push_cell(1); push_cell(2); push_cell(3);
        wait_cells(4);                           // user then idle
        cfg_hec_en = 0;
        push_cell(4); push_cell(5);
        wait_cells(3);                           // octet 5 passes through
        cfg_hec_en = 1; cfg_scr_en = 1;
        push_cell(6); push_cell(7);
        wait_cells(3);                           // scrambled, state carries on
        push_cell(8); push_cell(9); push_cell(10);
        step_cyc(20);
        req_oam(32'h0000_0018, 8'h6B);           // R2: OAM overtakes queued users
        wait_cells(5);
        stall_mode = 1;
        push_cell(11); push_cell(12);
        req_oam(32'h1234_5678, 8'hC3);
        wait_cells(5);
        stall_mode = 0;
        cfg_scr_en = 0;
        wait_cells(2);
        finish_run();
    end
endmodule